// File: doc/BRIEF.md
# Cascadable Iterative Magnitude Comparator

This block compares two unsigned words and raises exactly one of three outputs: less, equal or greater. It is built as a chain of 4-bit slices. Each slice is itself a chain of one-bit cells. Every cell takes the less, equal and greater state from the cell below it and passes its own state to the cell above it.

A more significant bit that differs overrides everything beneath it. A lower bit decides the result only while all bits above it are equal. The slice count is a parameter. The default of three slices gives a 12-bit comparator, in which slice k covers bits 4k to 4k+3.

The three cascade inputs of the lowest cell are brought out as ports. Tying them to less=0, equal=1, greater=0 gives a plain comparison. Feeding them from another comparator extends the word downward without glue logic. The block is purely combinational.

Top module: `mag_cmp_chain`

## Requirements
- R1: With cascade inputs less=0, equal=1, greater=0 and a_i > b_i (unsigned), gt_o=1, eq_o=0 and lt_o=0.
- R2: With cascade inputs less=0, equal=1, greater=0 and a_i < b_i (unsigned), lt_o=1, eq_o=0 and gt_o=0.
- R3: With cascade inputs less=0, equal=1, greater=0 and a_i == b_i, eq_o=1, lt_o=0 and gt_o=0.
- R4: Whenever exactly one cascade input is high, exactly one of lt_o, eq_o and gt_o is high.
- R5: When a more significant slice (bits 4k..4k+3) differs, its comparison alone sets the outputs, whatever the lower bits hold.
- R6: When the upper slices are equal, the lowest differing slice decides. With upper bits equal, a low nibble of 0011 against 0010 gives greater, and 0100 against 0101 gives less.
- R7: When a_i == b_i, the outputs {lt_o, eq_o, gt_o} equal the cascade inputs {cas_lt_i, cas_eq_i, cas_gt_i}, for all eight input combinations, including invalid ones.
- R8: When a_i != b_i, the cascade inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SLICES*SLICE_W | First operand, unsigned |
| b_i | input | SLICES*SLICE_W | Second operand, unsigned |
| cas_lt_i | input | 1 | Cascade less-than into the lowest cell |
| cas_eq_i | input | 1 | Cascade equal into the lowest cell |
| cas_gt_i | input | 1 | Cascade greater-than into the lowest cell |
| lt_o | output | 1 | a_i below b_i |
| eq_o | output | 1 | a_i equal to b_i (cascade-qualified) |
| gt_o | output | 1 | a_i above b_i |

## Verification
The bench builds the block with the default three slices of four bits. At 12 bits, the hand-picked slice-boundary cases can be swept completely. These include every low-nibble pair under several fixed upper bytes, and every cascade-input combination under both equal and unequal operands. A few thousand sampled operand pairs also cover carries of the decision across both slice boundaries.

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain #(
  parameter int SLICES  = 3,
  parameter int SLICE_W = 4
) (
  input  logic [SLICES*SLICE_W-1:0] a_i,
  input  logic [SLICES*SLICE_W-1:0] b_i,
  input  logic                      cas_lt_i,
  input  logic                      cas_eq_i,
  input  logic                      cas_gt_i,
  output logic                      lt_o,
  output logic                      eq_o,
  output logic                      gt_o
);
  localparam int W = SLICES * SLICE_W;

  logic [W:0] lt_c;
  logic [W:0] eq_c;
  logic [W:0] gt_c;

  assign lt_c[0] = cas_lt_i;
  assign eq_c[0] = cas_eq_i;
  assign gt_c[0] = cas_gt_i;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int LO = s * SLICE_W;
    localparam int HI = LO + SLICE_W;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_cell
      localparam int K = LO + i;
      logic same;
      assign same       = ~(a_i[K] ^ b_i[K]);
      assign eq_c[K+1]  = same & eq_c[K];
      assign gt_c[K+1]  = (a_i[K] & ~b_i[K]) | (same & gt_c[K]);
      assign lt_c[K+1]  = (~a_i[K] & b_i[K]) | (same & lt_c[K]);
    end

    always_comb begin
      if ($countones({lt_c[LO], eq_c[LO], gt_c[LO]}) == 1)
        AST_SLICE_ONE_HOT: assert ($countones({lt_c[HI], eq_c[HI], gt_c[HI]}) == 1); // R4
      if (a_i[HI-1:LO] != b_i[HI-1:LO])
        AST_SLICE_DECIDES: assert (gt_c[HI] == (a_i[HI-1:LO] > b_i[HI-1:LO])); // R5
    end
  end

  assign lt_o = lt_c[W];
  assign eq_o = eq_c[W];
  assign gt_o = gt_c[W];

  always_comb begin
    if ($countones({cas_lt_i, cas_eq_i, cas_gt_i}) == 1)
      AST_OUT_ONE_HOT: assert ($countones({lt_o, eq_o, gt_o}) == 1); // R4
    if (a_i == b_i)
      AST_EQUAL_PASS: assert ({lt_o, eq_o, gt_o} == {cas_lt_i, cas_eq_i, cas_gt_i}); // R7
    if (a_i != b_i)
      AST_UNEQUAL_DECIDED: assert (!eq_o && (gt_o == (a_i > b_i)) && (lt_o == (a_i < b_i))); // R8
    if (cas_eq_i && !cas_lt_i && !cas_gt_i && a_i > b_i)
      AST_GREATER: assert (gt_o && !lt_o && !eq_o); // R1
  end
endmodule

// File: tb/sim_mag_cmp_chain.sv
module sim_mag_cmp_chain;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic cl, ce, cg;
  logic lt, eq, gt;

  int checks = 0;
  int errors = 0;

  mag_cmp_chain u0 (
    .a_i(a), .b_i(b), .cas_lt_i(cl), .cas_eq_i(ce), .cas_gt_i(cg),
    .lt_o(lt), .eq_o(eq), .gt_o(gt)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic [2:0] cas, input string tag);
    logic [2:0] exp;
    @(posedge clk);
    a = av; b = bv; {cl, ce, cg} = cas;
    if (av > bv)      exp = 3'b001;
    else if (av < bv) exp = 3'b100;
    else              exp = cas;
    @(negedge clk);
    checks++;
    if ({lt, eq, gt} != exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cas=%b got lt/eq/gt=%b expected=%b",
               tag, av, bv, cas, {lt, eq, gt}, exp);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired got=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; {cl, ce, cg} = 3'b010;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(12'h000, 12'h000, 3'b010, "R3 reset idle");
    apply(12'hFFF, 12'hFFF, 3'b010, "R3 all ones");
    apply(12'h800, 12'h7FF, 3'b010, "R1 R5 msb decides");
    apply(12'h7FF, 12'h800, 3'b010, "R2 R5 msb decides");
    apply(12'h1D0, 12'h170, 3'b010, "R5 middle slice decides");
    apply(12'hA03, 12'hA02, 3'b010, "R6 low nibble 0011>0010");
    apply(12'hA04, 12'hA05, 3'b010, "R6 low nibble 0100<0101");
    apply(12'h109, 12'h109, 3'b010, "R3 low nibble 1001=1001");
    for (int u = 0; u < 4; u++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          logic [7:0] up;
          up = 8'(u * 67 + 5);
          apply({up, 4'(x)}, {up, 4'(y)}, 3'b010, "R6 equal upper bits");
        end
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 8; c++)
        apply({4'(m), 8'hC3}, {4'(m), 8'hC3}, 3'(c), "R7 equal passes cascade");
    for (int c = 0; c < 8; c++) begin
      apply(12'h351, 12'h350, 3'(c), "R8 cascade ignored gt");
      apply(12'h350, 12'h351, 3'(c), "R8 cascade ignored lt");
      apply(12'h400, 12'h3FF, 3'(c), "R8 R5 cascade ignored msb");
    end
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (n % 4 == 0) ? (ra ^ W'(1 << (n % W))) : W'($urandom);
      apply(ra, rb, 3'b010, "R1 R2 R4 sampled pair");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule